// File: doc/BRIEF.md
# Serial Byte Master with Select Fault Guard

This block drives a four-wire serial link as its clock owner. It derives the serial clock from the system clock through a 3-bit rate code, presents transmit bits on the data-out line, captures the data-in line, and moves one byte each time a transmit request is accepted. Clock polarity, clock phase and bit order can be chosen, so any of the four clock/data relationships can be used, with either end of the byte first.

The block only acts as clock owner while two internal bits, "master" and "enable", are set, and these bits only hold while the effective select line is high. That line comes either from an external pin or, when software select is enabled, from a software level. If the line goes low, for example because another clock owner has claimed the bus, both bits are cleared at once. Any transfer in progress is dropped, the serial clock goes back to idle, and a sticky fault flag is raised that software clears.

The transmit side uses a valid/ready handshake. A byte is taken on a cycle where `tx_valid` and `tx_ready` are both high. A `tx_valid` seen while `tx_ready` is low is not stored, so the producer must keep it up until it is accepted. The receive side has no back-pressure, because the serial link cannot be stalled. `rx_valid` pulses once with the byte and the consumer must take it in that cycle. The rate code, polarity, phase and bit order are captured when a byte is accepted.

Top module: `spi_mf_master`

## Requirements
- R1: The serial clock half-period is 2^code system clocks, where code is `cfg_div` captured at acceptance. A byte takes 16 half-periods, and edge k (k = 0..15) appears in the cycle after the rising system clock edge that comes (k+1)*2^code cycles after acceptance.
- R2: While no transfer runs, `sck` equals `cfg_cpol` as registered on the previous clock. It also returns to that level at the end of a transfer and on an abort.
- R3: With `cfg_cpha`=0, data-in is sampled on the odd-numbered edges (the first, third, and so on) and data-out advances on the even-numbered edges. With `cfg_cpha`=1, data-out advances on the odd-numbered edges after the first, and data-in is sampled on the even-numbered edges.
- R4: With `cfg_lsb_first`=0, bit 7 is sent first and the first received bit lands in `rx_data` bit 7. With `cfg_lsb_first`=1, bit 0 goes first and the first received bit lands in bit 0.
- R5: The effective select equals `sw_sel_level` when `sw_sel_en`=1, and `ss_in` otherwise.
- R6: When the effective select is low and the master bit is set, or is being written as 1, then on the next cycle `master_on` and `enable_on` are 0 and `mode_fault` is 1.
- R7: `mode_fault` stays at 1 until `fault_clr` is asserted in a cycle with no new fault. A new fault wins over a clear in the same cycle.
- R8: A select fault, or the master or enable bit being cleared, during a transfer ends it on the next clock. `busy` falls, `sck` goes idle, `mosi` goes to 0 and no `rx_valid` is produced.
- R9: `tx_ready` is high only when master and enable are set, the effective select is high and no transfer runs. `tx_valid` while `tx_ready` is low has no effect.
- R10: `rx_valid` is high for exactly one cycle, the cycle after the last edge, together with the received byte on `rx_data`. `mosi` is 0 whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 3 | Rate code; half-period is 2^code clocks |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Clock phase selection |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| ctrl_wr | input | 1 | Write strobe for the master/enable bits |
| ctrl_master | input | 1 | Value written to the master bit |
| ctrl_enable | input | 1 | Value written to the enable bit |
| sw_sel_en | input | 1 | Take select from software level instead of pin |
| sw_sel_level | input | 1 | Software select level |
| ss_in | input | 1 | Select input pin, must stay high |
| fault_clr | input | 1 | Clears the mode fault flag |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte can be accepted |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe, received byte complete |
| busy | output | 1 | Transfer in progress |
| mode_fault | output | 1 | Sticky select fault flag |
| master_on | output | 1 | Master bit state |
| enable_on | output | 1 | Enable bit state |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong divider count or edge index shows within one half-period as an `sck` transition in the wrong cycle. A wrong shift direction or sampling phase shows as a wrong `mosi` bit within a half-period, or as a corrupt `rx_data` at the end of the byte. A control bit that fails to clear on a select fault shows on `master_on`, `enable_on` and `mode_fault` one cycle after the select drops, and on `busy` and `sck` in the same cycle. The bench's reference model predicts every port on every clock, so any of these shows up as a mismatch in the cycle it first appears.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  localparam int unsigned DIV_W  = 3;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned EDGES  = 2 * DATA_W;
endpackage

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic ctrl_master,
  input  logic ctrl_enable,
  input  logic sw_sel_en,
  input  logic sw_sel_level,
  input  logic ss_in,
  input  logic fault_clr,
  output logic sel_ok,
  output logic master_q,
  output logic enable_q,
  output logic fault_q
);
  logic fault_now;

  assign sel_ok    = sw_sel_en ? sw_sel_level : ss_in;
  assign fault_now = !sel_ok && (master_q || (ctrl_wr && ctrl_master));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      enable_q <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      if (fault_now) begin
        master_q <= 1'b0;
        enable_q <= 1'b0;
      end else if (ctrl_wr) begin
        master_q <= ctrl_master;
        enable_q <= ctrl_enable;
      end
      if (fault_now)      fault_q <= 1'b1;
      else if (fault_clr) fault_q <= 1'b0;
    end
  end

  AST_FAULT_DROPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now |=> (!master_q && !enable_q && fault_q)); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !fault_clr) |=> fault_q); // R7
endmodule

// File: rtl/spi_mf_clkgen.sv
module spi_mf_clkgen #(
  parameter int unsigned DIV_W = spi_mf_pkg::DIV_W,
  parameter int unsigned EDGES = spi_mf_pkg::EDGES,
  localparam int unsigned CNT_W  = (1 << DIV_W) - 1,
  localparam int unsigned EIDX_W = $clog2(EDGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [DIV_W-1:0]  div_code,
  input  logic              cpol,
  output logic              busy,
  output logic              sck,
  output logic              edge_evt,
  output logic [EIDX_W-1:0] edge_idx
);
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;
  logic             last_edge;

  assign half_m1   = CNT_W'((32'd1 << div_q) - 32'd1);
  assign edge_evt  = busy && !abort && (cnt_q == half_m1);
  assign last_edge = edge_evt && (edge_idx == EIDX_W'(EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sck      <= 1'b0;
      cnt_q    <= '0;
      edge_idx <= '0;
      div_q    <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      sck  <= cpol;
    end else if (start) begin
      busy     <= 1'b1;
      sck      <= cpol;
      cnt_q    <= '0;
      edge_idx <= '0;
      div_q    <= div_code;
    end else if (busy) begin
      if (edge_evt) begin
        cnt_q    <= '0;
        sck      <= ~sck;
        edge_idx <= edge_idx + 1'b1;
        if (last_edge) busy <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      sck <= cpol;
    end
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (sck == $past(cpol))); // R2
  AST_LAST_EDGE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last_edge |=> !busy); // R1
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> !busy); // R8
endmodule

// File: rtl/spi_mf_shifter.sv
module spi_mf_shifter #(
  parameter int unsigned DATA_W = spi_mf_pkg::DATA_W,
  localparam int unsigned EDGES  = 2 * DATA_W,
  localparam int unsigned EIDX_W = $clog2(EDGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              busy,
  input  logic              edge_evt,
  input  logic [EIDX_W-1:0] edge_idx,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  logic              cpha_q, lsb_q;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_upd;
  logic              odd_edge, do_sample, do_shift, last_edge;

  assign odd_edge  = edge_idx[0];
  assign do_sample = edge_evt && (cpha_q ? odd_edge : !odd_edge);
  assign do_shift  = edge_evt && (cpha_q ? (!odd_edge && edge_idx != '0) : odd_edge);
  assign last_edge = edge_evt && (edge_idx == EIDX_W'(EDGES - 1));
  assign mosi      = busy && (lsb_q ? tx_sh[0] : tx_sh[DATA_W-1]);

  always_comb begin
    rx_upd = rx_sh;
    if (do_sample)
      rx_upd = lsb_q ? {miso, rx_sh[DATA_W-1:1]} : {rx_sh[DATA_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpha_q   <= 1'b0;
      lsb_q    <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= last_edge;
      if (start) begin
        cpha_q <= cpha;
        lsb_q  <= lsb_first;
        tx_sh  <= tx_data;
        rx_sh  <= '0;
      end else begin
        rx_sh <= rx_upd;
        if (do_shift) tx_sh <= lsb_q ? (tx_sh >> 1) : (tx_sh << 1);
        if (last_edge) rx_data <= rx_upd;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R10
  AST_MOSI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mosi); // R10
endmodule

// File: rtl/spi_mf_master.sv
module spi_mf_master (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [spi_mf_pkg::DIV_W-1:0]   cfg_div,
  input  logic                           cfg_cpol,
  input  logic                           cfg_cpha,
  input  logic                           cfg_lsb_first,
  input  logic                           ctrl_wr,
  input  logic                           ctrl_master,
  input  logic                           ctrl_enable,
  input  logic                           sw_sel_en,
  input  logic                           sw_sel_level,
  input  logic                           ss_in,
  input  logic                           fault_clr,
  input  logic [spi_mf_pkg::DATA_W-1:0]  tx_data,
  input  logic                           tx_valid,
  output logic                           tx_ready,
  output logic [spi_mf_pkg::DATA_W-1:0]  rx_data,
  output logic                           rx_valid,
  output logic                           busy,
  output logic                           mode_fault,
  output logic                           master_on,
  output logic                           enable_on,
  output logic                           sck,
  output logic                           mosi,
  input  logic                           miso
);
  localparam int unsigned EIDX_W = $clog2(spi_mf_pkg::EDGES);

  logic              sel_ok, active, start, abort, edge_evt;
  logic [EIDX_W-1:0] edge_idx;

  spi_mf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_master(ctrl_master),
    .ctrl_enable(ctrl_enable), .sw_sel_en(sw_sel_en), .sw_sel_level(sw_sel_level),
    .ss_in(ss_in), .fault_clr(fault_clr), .sel_ok(sel_ok),
    .master_q(master_on), .enable_q(enable_on), .fault_q(mode_fault)
  );

  assign active   = master_on && enable_on;
  assign tx_ready = active && sel_ok && !busy;
  assign start    = tx_valid && tx_ready;
  assign abort    = busy && (!sel_ok || !active);

  spi_mf_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .div_code(cfg_div),
    .cpol(cfg_cpol), .busy(busy), .sck(sck), .edge_evt(edge_evt), .edge_idx(edge_idx)
  );

  spi_mf_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data), .cpha(cfg_cpha),
    .lsb_first(cfg_lsb_first), .busy(busy), .edge_evt(edge_evt), .edge_idx(edge_idx),
    .miso(miso), .mosi(mosi), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  AST_READY_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tx_ready); // R9
  AST_NO_START_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tx_ready) |=> !busy); // R9
endmodule

// File: tb/spi_mf_master_test.sv
module spi_mf_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_div = 3'd0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic ctrl_wr = 1'b0, ctrl_master = 1'b0, ctrl_enable = 1'b0;
  logic sw_sel_en = 1'b0, sw_sel_level = 1'b0, ss_in = 1'b1, fault_clr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0;
  logic miso = 1'b0;
  logic tx_ready, rx_valid, busy, mode_fault, master_on, enable_on, sck, mosi;
  logic [7:0] rx_data;
  logic [7:0] slave_byte = 8'h00;

  int checks = 0, errors = 0, cycles = 0;

  // reference model state
  bit m_master = 0, m_enable = 0, m_fault = 0, m_busy = 0, m_sck = 0, m_rxv = 0;
  bit m_cpha = 0, m_lsb = 0;
  int m_div = 0, m_cnt = 0, m_edges = 0, m_samples = 0;
  bit [7:0] m_tx = 0, m_rxbuf = 0, m_rxd = 0;

  spi_mf_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .ctrl_wr(ctrl_wr), .ctrl_master(ctrl_master),
    .ctrl_enable(ctrl_enable), .sw_sel_en(sw_sel_en), .sw_sel_level(sw_sel_level),
    .ss_in(ss_in), .fault_clr(fault_clr), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy),
    .mode_fault(mode_fault), .master_on(master_on), .enable_on(enable_on),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int pos(input bit lsb, input int k);
    return lsb ? k : 7 - k;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  function automatic bit exp_mosi();
    int b;
    if (!m_busy) return 0;
    b = m_cpha ? ((m_edges == 0) ? 0 : (m_edges - 1) / 2) : m_edges / 2;
    return m_tx[pos(m_lsb, b)];
  endfunction

  always @(negedge clk) begin
    bit sel, fnow, act, rdy, strt, abrt, smp;
    cycles++;
    chk("R1 R2 R3 R8 sck", int'(sck), int'(m_sck));
    chk("R1 R8 busy", int'(busy), int'(m_busy));
    chk("R3 R4 R10 mosi", int'(mosi), int'(exp_mosi()));
    chk("R10 rx_valid", int'(rx_valid), int'(m_rxv));
    chk("R4 R10 rx_data", int'(rx_data), int'(m_rxd));
    chk("R5 R6 master_on", int'(master_on), int'(m_master));
    chk("R6 enable_on", int'(enable_on), int'(m_enable));
    chk("R6 R7 mode_fault", int'(mode_fault), int'(m_fault));
    chk("R9 tx_ready", int'(tx_ready), int'(m_master && m_enable && !m_busy &&
        (sw_sel_en ? sw_sel_level : ss_in)));
    miso = m_busy ? slave_byte[pos(m_lsb, m_samples % 8)] : 1'b0;
    if (!rst_n) begin
      m_master = 0; m_enable = 0; m_fault = 0; m_busy = 0; m_sck = 0; m_rxv = 0;
      m_rxd = 0; m_cpha = 0; m_lsb = 0; m_edges = 0;
    end else begin
      sel  = sw_sel_en ? sw_sel_level : ss_in;
      fnow = !sel && (m_master || (ctrl_wr && ctrl_master));
      act  = m_master && m_enable;
      rdy  = act && sel && !m_busy;
      strt = tx_valid && rdy;
      abrt = m_busy && (!sel || !act);
      m_rxv = 0;
      if (abrt) begin
        m_busy = 0; m_sck = cfg_cpol;
      end else if (strt) begin
        m_busy = 1; m_sck = cfg_cpol; m_cnt = 0; m_edges = 0; m_samples = 0;
        m_div = int'(cfg_div); m_cpha = cfg_cpha; m_lsb = cfg_lsb_first;
        m_tx = tx_data; m_rxbuf = 0;
      end else if (m_busy) begin
        if (m_cnt == (1 << m_div) - 1) begin
          m_cnt = 0;
          m_sck = !m_sck;
          smp = m_cpha ? (m_edges % 2 == 1) : (m_edges % 2 == 0);
          if (smp) begin
            m_rxbuf[pos(m_lsb, m_samples)] = miso;
            m_samples++;
          end
          m_edges++;
          if (m_edges == 16) begin
            m_busy = 0; m_rxv = 1; m_rxd = m_rxbuf;
          end
        end else m_cnt++;
      end else m_sck = cfg_cpol;
      if (fnow) begin
        m_master = 0; m_enable = 0;
      end else if (ctrl_wr) begin
        m_master = ctrl_master; m_enable = ctrl_enable;
      end
      if (fnow) m_fault = 1;
      else if (fault_clr) m_fault = 0;
    end
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_ctrl(input bit m, input bit e);
    ctrl_wr = 1; ctrl_master = m; ctrl_enable = e;
    tick(1);
    ctrl_wr = 0;
    tick(1);
  endtask

  task automatic wait_idle();
    while (m_busy) tick(1);
    tick(2);
  endtask

  // R1 R2 R3 R4 R10: one full transfer under a given configuration
  task automatic xfer(input int dv, input bit pol, input bit pha, input bit lsb,
                      input bit [7:0] d, input bit [7:0] s);
    cfg_div = 3'(dv); cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb;
    slave_byte = s;
    tick(2);
    tx_data = d; tx_valid = 1;
    tick(1);
    tx_valid = 0;
    wait_idle();
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    wr_ctrl(1, 1);
    xfer(0, 0, 0, 0, 8'hA5, 8'h3C);
    xfer(1, 0, 1, 0, 8'h96, 8'hC3);
    xfer(2, 1, 0, 1, 8'h1E, 8'h81);
    xfer(0, 1, 1, 1, 8'hF0, 8'h5A);
    xfer(3, 0, 0, 1, 8'h01, 8'h80);
    xfer(7, 1, 1, 0, 8'h7E, 8'hE7);
    // R9: request while busy is ignored
    cfg_div = 3'd1; slave_byte = 8'h24;
    tx_data = 8'h42; tx_valid = 1; tick(1); tx_valid = 0;
    tick(5);
    tx_data = 8'hFF; tx_valid = 1; tick(1); tx_valid = 0;
    wait_idle();
    // R8 R6: select pin drops mid-transfer
    cfg_div = 3'd2; tx_data = 8'hC9; tx_valid = 1; tick(1); tx_valid = 0;
    tick(19);
    ss_in = 0; tick(3);
    // R9: request while inactive is ignored
    tx_valid = 1; tick(2); tx_valid = 0;
    ss_in = 1; tick(3);
    // R7: sticky until cleared
    fault_clr = 1; tick(1); fault_clr = 0; tick(2);
    // R7: set wins over clear in the same cycle
    ss_in = 0; ctrl_wr = 1; ctrl_master = 1; ctrl_enable = 1; fault_clr = 1;
    tick(1); ctrl_wr = 0; fault_clr = 0; tick(2);
    ss_in = 1; fault_clr = 1; tick(1); fault_clr = 0;
    // R5: software select overrides the pin
    wr_ctrl(1, 1);
    sw_sel_en = 1; sw_sel_level = 0; tick(3);
    fault_clr = 1; tick(1); fault_clr = 0;
    sw_sel_level = 1; ss_in = 0;
    wr_ctrl(1, 1);
    xfer(1, 0, 0, 0, 8'h5C, 8'hA3);
    // R8: clearing master mid-transfer aborts
    cfg_div = 3'd1; tx_data = 8'h33; tx_valid = 1; tick(1); tx_valid = 0;
    tick(6);
    wr_ctrl(0, 1);
    tick(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule